// File: doc/BRIEF.md
# Shaped Output Merger with Copy-Count Release

This block merges packet descriptors from several upstream queue managers onto one output. Each manager hands over one descriptor at a time: a pointer, a byte length, a 2-bit copy count and a single-copy flag. The descriptor goes into a one-entry slot for that manager, and the manager gets its own ready signal back. Every manager has its own token bucket. The bucket refills by a programmable rate each cycle and is clipped at a programmable burst size. A held descriptor may leave only when its bucket holds at least its length. Among the managers that may send, a round-robin pointer picks one per cycle.

A packet that is copied toward several managers shares one buffer pointer. The block keeps a small remaining-copies counter for each pointer. It counts every copy that is transmitted and every copy that comes in on the drop input, and it raises a free-pointer request once the last copy has been counted. A copy dropped on one path and transmitted on another is therefore released correctly. A descriptor marked single-copy releases its pointer at once. Drops use the counter only in cycles with no transmission. Free requests leave on a valid/ready port, and while a request is pending and not taken, the block does not transmit or accept drops.

Top module: `shaped_merger`

## Requirements
- R1: After reset, out_valid and free_valid are low, every in_ready bit is high and drop_ready is high.
- R2: Each source holds at most one descriptor. in_ready[i] is high only when that slot is empty or its descriptor departs in the current cycle. While a descriptor waits, no further descriptor is taken from that source.
- R3: A source's credit is zero after reset. On every clock edge it gains the source's rate and is clipped at the source's burst. It loses the descriptor length on the edge where that descriptor departs. A descriptor departs only when the credit is at least its length, and out_valid shows it for one cycle after that edge.
- R4: When several sources may send, the grant rotates round-robin, starting with the source after the one granted last.
- R5: A descriptor with in_single (or drop_single) set produces one free request for its pointer when it is transmitted or accepted on the drop input.
- R6: For a descriptor with the single flag clear, the 2-bit count field gives the number of copies (value 0 means four). Transmitted and dropped copies of a pointer are counted together, and exactly one free request is raised, after the last copy.
- R7: drop_ready is high only in cycles with no transmission, and dropped descriptors never appear on the output.
- R8: A free request holds free_valid and free_ptr steady until free_ready. While it waits without free_ready, nothing is transmitted and no drop is accepted.
- R9: A write with cfg_we sets the rate and burst of source cfg_idx only.
- R10: Every accepted descriptor leaves the output exactly once, with its source index, pointer and length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | N_SRC | Descriptor offered, per source |
| in_ready | output | N_SRC | Slot can take a descriptor, per source |
| in_ptr | input | N_SRC*PTR_W | Buffer pointers, source i in slice i |
| in_len | input | N_SRC*LEN_W | Packet lengths in bytes |
| in_cnt | input | N_SRC*2 | Copy counts (0 means four) |
| in_single | input | N_SRC | Single-copy flag, frees directly |
| drop_valid | input | 1 | Dropped descriptor offered |
| drop_ready | output | 1 | Drop accepted this cycle |
| drop_ptr | input | PTR_W | Pointer of dropped copy |
| drop_cnt | input | 2 | Copy count of dropped copy |
| drop_single | input | 1 | Single-copy flag of dropped copy |
| cfg_we | input | 1 | Bucket configuration write |
| cfg_idx | input | SRC_W | Source addressed by the write |
| cfg_rate | input | RATE_W | Credit added per cycle |
| cfg_burst | input | CRED_W | Credit ceiling |
| out_valid | output | 1 | Descriptor transmitted |
| out_src | output | SRC_W | Source of transmitted descriptor |
| out_ptr | output | PTR_W | Pointer of transmitted descriptor |
| out_len | output | LEN_W | Length of transmitted descriptor |
| free_valid | output | 1 | Free-pointer request pending |
| free_ready | input | 1 | Free request taken |
| free_ptr | output | PTR_W | Pointer to release |

## Verification
The bench builds the block with three sources and 4-bit pointers. Three is not a power of two, so the round-robin pointer has to wrap past an index that does not exist. With only sixteen pointers, the random phase reuses each pointer many times, which puts the live-entry clearing in the copy counter under steady pressure. The random phase mixes multi-copy packets across sources and the drop path with a randomly stalling free port. Directed runs pin down the exact departure cycle of one bucket, the burst ceiling with back-to-back descriptors, strict rotation under full backlog, and the drop path yielding to transmission.

// File: rtl/shaped_merger.sv
module shaped_merger #(
  parameter int N_SRC  = 4,
  parameter int PTR_W  = 6,
  parameter int LEN_W  = 11,
  parameter int RATE_W = 8,
  parameter int CRED_W = 16,
  parameter int SRC_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_SRC-1:0]         in_valid,
  output logic [N_SRC-1:0]         in_ready,
  input  logic [N_SRC*PTR_W-1:0]   in_ptr,
  input  logic [N_SRC*LEN_W-1:0]   in_len,
  input  logic [N_SRC*2-1:0]       in_cnt,
  input  logic [N_SRC-1:0]         in_single,
  input  logic                     drop_valid,
  output logic                     drop_ready,
  input  logic [PTR_W-1:0]         drop_ptr,
  input  logic [1:0]               drop_cnt,
  input  logic                     drop_single,
  input  logic                     cfg_we,
  input  logic [SRC_W-1:0]         cfg_idx,
  input  logic [RATE_W-1:0]        cfg_rate,
  input  logic [CRED_W-1:0]        cfg_burst,
  output logic                     out_valid,
  output logic [SRC_W-1:0]         out_src,
  output logic [PTR_W-1:0]         out_ptr,
  output logic [LEN_W-1:0]         out_len,
  output logic                     free_valid,
  input  logic                     free_ready,
  output logic [PTR_W-1:0]         free_ptr
);
  localparam int DEPTH = 1 << PTR_W;

  logic [N_SRC-1:0]        full, elig, pop, sng;
  logic [N_SRC*PTR_W-1:0]  s_ptr;
  logic [N_SRC*LEN_W-1:0]  s_len;
  logic [N_SRC*2-1:0]      s_cnt;
  logic [N_SRC*CRED_W-1:0] cred_f, burst_f;
  logic [SRC_W-1:0]        rr, gnt;
  logic                    any_tx, free_ok, drop_fire, ev, ev_single, ev_free;
  logic [PTR_W-1:0]        ev_ptr;
  logic [1:0]              ev_cnt, base, nxt;
  logic [1:0]              rem_mem [DEPTH];
  logic [DEPTH-1:0]        live;

  assign free_ok = !free_valid || free_ready;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic              full_q, sng_q;
    logic [PTR_W-1:0]  ptr_q;
    logic [LEN_W-1:0]  len_q;
    logic [1:0]        cnt_q;
    logic [CRED_W-1:0] credit, burst;
    logic [RATE_W-1:0] rate;
    logic [CRED_W:0]   fill;

    assign fill = {1'b0, credit} + (CRED_W+1)'(rate)
                - (pop[i] ? (CRED_W+1)'(len_q) : '0);
    assign elig[i]     = full_q && (credit >= CRED_W'(len_q));
    assign in_ready[i] = !full_q || pop[i];
    assign full[i]     = full_q;
    assign sng[i]      = sng_q;
    assign s_ptr[i*PTR_W +: PTR_W]    = ptr_q;
    assign s_len[i*LEN_W +: LEN_W]    = len_q;
    assign s_cnt[i*2 +: 2]            = cnt_q;
    assign cred_f[i*CRED_W +: CRED_W]  = credit;
    assign burst_f[i*CRED_W +: CRED_W] = burst;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        full_q <= 1'b0;
        sng_q  <= 1'b0;
        ptr_q  <= '0;
        len_q  <= '0;
        cnt_q  <= '0;
        credit <= '0;
        burst  <= '0;
        rate   <= '0;
      end else begin
        if (in_valid[i] && in_ready[i]) begin
          full_q <= 1'b1;
          ptr_q  <= in_ptr[i*PTR_W +: PTR_W];
          len_q  <= in_len[i*LEN_W +: LEN_W];
          cnt_q  <= in_cnt[i*2 +: 2];
          sng_q  <= in_single[i];
        end else if (pop[i]) begin
          full_q <= 1'b0;
        end
        credit <= (fill > {1'b0, burst}) ? burst : fill[CRED_W-1:0];
        if (cfg_we && cfg_idx == SRC_W'(i)) begin
          rate  <= cfg_rate;
          burst <= cfg_burst;
        end
      end
    end
  end

  always_comb begin
    any_tx = 1'b0;
    gnt    = rr;
    for (int k = 0; k < N_SRC; k++) begin
      int j;
      j = (int'(rr) + k) % N_SRC;
      if (!any_tx && free_ok && elig[j]) begin
        any_tx = 1'b1;
        gnt    = SRC_W'(j);
      end
    end
  end

  assign pop        = any_tx ? (N_SRC'(1) << gnt) : '0;
  assign drop_ready = free_ok && !any_tx;
  assign drop_fire  = drop_valid && drop_ready;

  assign ev        = any_tx || drop_fire;
  assign ev_ptr    = any_tx ? s_ptr[gnt*PTR_W +: PTR_W] : drop_ptr;
  assign ev_cnt    = any_tx ? s_cnt[gnt*2 +: 2] : drop_cnt;
  assign ev_single = any_tx ? sng[gnt] : drop_single;
  assign base      = live[ev_ptr] ? rem_mem[ev_ptr] : ev_cnt;
  assign nxt       = base - 2'd1;
  assign ev_free   = ev_single || (nxt == 2'd0);

  always_ff @(posedge clk) begin
    if (ev && !ev_single) rem_mem[ev_ptr] <= nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live       <= '0;
      rr         <= '0;
      out_valid  <= 1'b0;
      out_src    <= '0;
      out_ptr    <= '0;
      out_len    <= '0;
      free_valid <= 1'b0;
      free_ptr   <= '0;
    end else begin
      if (ev && !ev_single) live[ev_ptr] <= (nxt != 2'd0);
      out_valid <= any_tx;
      if (any_tx) begin
        out_src <= gnt;
        out_ptr <= s_ptr[gnt*PTR_W +: PTR_W];
        out_len <= s_len[gnt*LEN_W +: LEN_W];
        rr      <= (gnt == SRC_W'(N_SRC-1)) ? '0 : gnt + 1'b1;
      end
      if (ev && ev_free) begin
        free_valid <= 1'b1;
        free_ptr   <= ev_ptr;
      end else if (free_ready) begin
        free_valid <= 1'b0;
      end
    end
  end
endmodule

module merger_chk #(
  parameter int N_SRC  = 4,
  parameter int PTR_W  = 6,
  parameter int CRED_W = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cfg_we,
  input logic                     drop_valid,
  input logic                     drop_ready,
  input logic                     out_valid,
  input logic                     free_valid,
  input logic                     free_ready,
  input logic [PTR_W-1:0]         free_ptr,
  input logic [N_SRC*CRED_W-1:0]  cred_f,
  input logic [N_SRC*CRED_W-1:0]  burst_f
);
  // R8
  free_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free_valid && !free_ready) |=> (free_valid && $stable(free_ptr)));

  // R8
  free_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free_valid && !free_ready) |=> !out_valid);

  // R7
  drop_yield_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_valid && drop_ready) |=> !out_valid);

  for (genvar g = 0; g < N_SRC; g++) begin : g_cap
    // R3
    credit_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cfg_we) |-> (cred_f[g*CRED_W +: CRED_W] <= burst_f[g*CRED_W +: CRED_W]));
  end
endmodule

bind shaped_merger merger_chk #(.N_SRC(N_SRC), .PTR_W(PTR_W), .CRED_W(CRED_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .drop_valid(drop_valid),
  .drop_ready(drop_ready), .out_valid(out_valid), .free_valid(free_valid),
  .free_ready(free_ready), .free_ptr(free_ptr), .cred_f(cred_f), .burst_f(burst_f)
);

// File: tb/shaped_merger_bench.sv
module shaped_merger_bench;
  localparam int N = 3, PW = 4, LW = 11, RW = 8, CW = 16, SW = 2;

  typedef struct packed {
    logic [PW-1:0] ptr;
    logic [LW-1:0] len;
    logic [1:0]    cnt;
    logic          single;
    logic [1:0]    tgt;
  } desc_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] in_valid = '0, in_ready, in_single;
  logic [N*PW-1:0] in_ptr;
  logic [N*LW-1:0] in_len;
  logic [N*2-1:0] in_cnt;
  logic drop_valid = 1'b0, drop_ready;
  logic cfg_we = 1'b0;
  logic [SW-1:0] cfg_idx = '0;
  logic [RW-1:0] cfg_rate = '0;
  logic [CW-1:0] cfg_burst = '0;
  logic out_valid, free_valid, free_ready = 1'b1;
  logic [SW-1:0] out_src;
  logic [PW-1:0] out_ptr, free_ptr;
  logic [LW-1:0] out_len;
  desc_t d_in [N];
  desc_t d_drop;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      in_ptr[i*PW +: PW] = d_in[i].ptr;
      in_len[i*LW +: LW] = d_in[i].len;
      in_cnt[i*2 +: 2]   = d_in[i].cnt;
      in_single[i]       = d_in[i].single;
    end
  end

  shaped_merger #(.N_SRC(N), .PTR_W(PW), .LEN_W(LW), .RATE_W(RW), .CRED_W(CW), .SRC_W(SW)) u_shaped_merger (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_ptr(in_ptr),
    .in_len(in_len), .in_cnt(in_cnt), .in_single(in_single), .drop_valid(drop_valid),
    .drop_ready(drop_ready), .drop_ptr(d_drop.ptr), .drop_cnt(d_drop.cnt),
    .drop_single(d_drop.single), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_rate(cfg_rate),
    .cfg_burst(cfg_burst), .out_valid(out_valid), .out_src(out_src), .out_ptr(out_ptr),
    .out_len(out_len), .free_valid(free_valid), .free_ready(free_ready), .free_ptr(free_ptr)
  );

  int checks = 0, fails = 0, cyc = 0, frees_seen = 0, last_out_cyc = 0;
  int last_src = -1;
  bit drop_acc = 0, done = 0;
  desc_t slot [N];
  bit slot_v [N];
  int rem [1<<PW];
  bit busy [1<<PW];
  int exp_free [$];
  desc_t job_q [$];
  longint bytes [N];
  int rate_v [N], burst_v [N], cyc_cfg [N];

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic void model_ev(desc_t d);
    if (d.single) exp_free.push_back(int'(d.ptr));
    else begin
      if (rem[d.ptr] == 0) rem[d.ptr] = (d.cnt == 0) ? 4 : int'(d.cnt);
      rem[d.ptr]--;
      if (rem[d.ptr] == 0) exp_free.push_back(int'(d.ptr));
    end
  endfunction

  task automatic tick();
    desc_t nw [N];
    logic [N-1:0] acc;
    #1;
    acc = '0;
    for (int i = 0; i < N; i++)
      if (in_valid[i] && in_ready[i]) begin acc[i] = 1'b1; nw[i] = d_in[i]; end
    drop_acc = drop_valid && drop_ready;
    if (drop_acc) model_ev(d_drop);
    if (free_valid && free_ready) begin
      // R5 R6: free order and pointer
      chk(exp_free.size() != 0 && exp_free[0] == int'(free_ptr), "R6 free pointer",
          free_ptr, exp_free.size() != 0 ? exp_free[0] : -1);
      if (exp_free.size() != 0) void'(exp_free.pop_front());
      busy[free_ptr] = 0;
      frees_seen++;
    end
    @(posedge clk);
    @(negedge clk);
    cyc++;
    if (drop_acc) drop_valid = 1'b0;
    if (out_valid) begin
      // R10: departure matches held descriptor
      chk(slot_v[out_src] && slot[out_src].ptr == out_ptr && slot[out_src].len == out_len,
          "R10 output descriptor", out_ptr, slot[out_src].ptr);
      slot_v[out_src] = 0;
      bytes[out_src] += out_len;
      last_out_cyc = cyc;
      model_ev(slot[out_src]);
    end
    for (int i = 0; i < N; i++)
      if (acc[i]) begin slot[i] = nw[i]; slot_v[i] = 1; in_valid[i] = 1'b0; end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = '0; drop_valid = 1'b0; cfg_we = 1'b0; free_ready = 1'b1;
    for (int i = 0; i < N; i++) begin slot_v[i] = 0; bytes[i] = 0; end
    for (int p = 0; p < (1<<PW); p++) begin rem[p] = 0; busy[p] = 0; end
    exp_free.delete();
    job_q.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic cfg(int i, int r, int b);
    cfg_we = 1'b1; cfg_idx = SW'(i); cfg_rate = RW'(r); cfg_burst = CW'(b);
    tick();
    cfg_we = 1'b0;
    rate_v[i] = r; burst_v[i] = b; cyc_cfg[i] = cyc;
  endtask

  function automatic desc_t mk(int p, int l, int c, bit s);
    desc_t d;
    d.ptr = PW'(p); d.len = LW'(l); d.cnt = 2'(c); d.single = s; d.tgt = '0;
    return d;
  endfunction

  task automatic offer_src(int i, desc_t d);
    d_in[i] = d; in_valid[i] = 1'b1;
    for (int t = 0; t < 100 && in_valid[i]; t++) tick();
    for (int t = 0; t < 300 && slot_v[i]; t++) tick();
    repeat (2) tick();
  endtask

  task automatic offer_drop(desc_t d);
    d_drop = d; drop_valid = 1'b1;
    for (int t = 0; t < 100 && drop_valid; t++) tick();
    repeat (2) tick();
  endtask

  function automatic int alloc();
    for (int t = 0; t < 24; t++) begin
      int p;
      p = int'($urandom % (1<<PW));
      if (!busy[p]) begin busy[p] = 1; return p; end
    end
    return -1;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int f0, t0, prev, mid_cyc;
    longint mid_bytes [N];
    void'($urandom(32'h5eed_0017));
    for (int i = 0; i < N; i++) d_in[i] = '0;
    d_drop = '0;
    do_reset();

    // R1: reset state
    #1;
    chk(!out_valid, "R1 out_valid", out_valid, 0);
    chk(!free_valid, "R1 free_valid", free_valid, 0);
    chk(in_ready == '1, "R1 in_ready", in_ready, 3'b111);
    chk(drop_ready, "R1 drop_ready", drop_ready, 1);

    // R2 R3 R9: zero rate holds; exact departure cycle after configuration
    d_in[0] = mk(1, 40, 0, 1); in_valid[0] = 1'b1;
    d_in[1] = mk(2, 10, 0, 1); in_valid[1] = 1'b1;
    tick();
    repeat (3) tick();
    #1;
    chk(in_ready[0] == 1'b0, "R2 held slot blocks", in_ready[0], 0);
    chk(!out_valid, "R3 zero credit holds", out_valid, 0);
    cfg(0, 4, 100);
    for (int k = 1; k <= 11; k++) begin
      tick();
      chk(out_valid == (k == 11), "R3 departure cycle", out_valid, k == 11);
    end
    #1;
    chk(in_ready[1] == 1'b0 && slot_v[1], "R9 other source unconfigured", in_ready[1], 0);
    chk(free_valid && free_ptr == 1, "R5 single copy frees", free_ptr, 1);
    for (int i = 0; i < N; i++) cfg(i, 255, 1000);
    repeat (4) tick();

    // R8: pending free stalls traffic
    free_ready = 1'b0;
    offer_src(0, mk(5, 10, 0, 1));
    d_in[0] = mk(6, 10, 0, 1); in_valid[0] = 1'b1;
    d_drop = mk(7, 10, 0, 1); drop_valid = 1'b1;
    for (int k = 0; k < 4; k++) begin
      tick();
      chk(free_valid && free_ptr == 5, "R8 free held", free_ptr, 5);
      chk(!out_valid && !drop_acc, "R8 stalled", out_valid, 0);
    end
    free_ready = 1'b1;
    for (int k = 0; k < 12; k++) tick();
    chk(frees_seen >= 4, "R8 released after ready", frees_seen, 4);

    // R6: three copies across transmit and drop
    f0 = frees_seen;
    offer_src(0, mk(8, 20, 3, 0));
    chk(frees_seen == f0, "R6 no free after copy 1", frees_seen, f0);
    offer_drop(mk(8, 20, 3, 0));
    chk(frees_seen == f0, "R6 no free after copy 2", frees_seen, f0);
    offer_src(1, mk(8, 20, 3, 0));
    chk(frees_seen == f0 + 1, "R6 free after last copy", frees_seen, f0 + 1);
    // R6: count field 0 means four copies
    f0 = frees_seen;
    for (int c = 0; c < 3; c++) offer_drop(mk(9, 20, 0, 0));
    chk(frees_seen == f0, "R6 four-copy not yet freed", frees_seen, f0);
    offer_src(2, mk(9, 20, 0, 0));
    chk(frees_seen == f0 + 1, "R6 four-copy freed", frees_seen, f0 + 1);

    // R4 R7: full backlog rotates, drop waits
    prev = -1;
    d_drop = mk(15, 5, 0, 1); drop_valid = 1'b1; busy[15] = 1;
    for (int k = 0; k < 30; k++) begin
      for (int i = 0; i < N; i++)
        if (!in_valid[i]) begin
          int p;
          p = alloc();
          if (p >= 0) begin d_in[i] = mk(p, 10, 0, 1); in_valid[i] = 1'b1; end
        end
      tick();
      if (k >= 2) begin
        chk(!drop_acc, "R7 drop yields to transmit", drop_acc, 0);
        chk(out_valid, "R4 continuous grant", out_valid, 1);
        if (out_valid && prev >= 0)
          chk(int'(out_src) == (prev + 1) % N, "R4 rotation", out_src, (prev + 1) % N);
      end
      if (out_valid) prev = int'(out_src);
    end
    in_valid = '0;
    for (int k = 0; k < 10 && drop_valid; k++) tick();
    chk(!drop_valid, "R7 drop accepted when idle", drop_valid, 0);
    repeat (10) tick();

    // R3: burst ceiling spaces back-to-back descriptors
    cfg(0, 50, 60);
    repeat (6) tick();
    t0 = 0;
    for (int n = 0; n < 3; n++) begin
      d_in[0] = mk(10 + n, 60, 0, 1); in_valid[0] = 1'b1;
      for (int t = 0; t < 20; t++) begin
        tick();
        if (out_valid) begin
          if (n > 0) chk(cyc - t0 == 2, "R3 burst ceiling spacing", cyc - t0, 2);
          t0 = cyc;
          break;
        end
      end
      if (in_valid[0]) in_valid[0] = 1'b0;
    end
    repeat (10) tick();

    // Random phase: R2 R3 R5 R6 R7 R8 R10
    do_reset();
    for (int i = 0; i < N; i++) cfg(i, 8 + int'($urandom % 33), 200 + int'($urandom % 401));
    mid_cyc = 0;
    for (int k = 0; k < 3000; k++) begin
      if (job_q.size() < 6) begin
        int p;
        p = alloc();
        if (p >= 0) begin
          int c, copies, l;
          bit s;
          s = ($urandom % 2) == 0;
          c = int'($urandom % 4);
          copies = s ? 1 : (c == 0 ? 4 : c);
          l = 1 + int'($urandom % 200);
          for (int j = 0; j < copies; j++) begin
            desc_t d;
            d = mk(p, l, c, s);
            d.tgt = 2'($urandom % (N + 1));
            job_q.push_back(d);
          end
        end
      end
      for (int i = 0; i <= N; i++) begin
        bit idle;
        idle = (i < N) ? !in_valid[i] : !drop_valid;
        if (idle && ($urandom % 3) != 0)
          for (int j = 0; j < job_q.size(); j++)
            if (int'(job_q[j].tgt) == i) begin
              if (i < N) begin d_in[i] = job_q[j]; in_valid[i] = 1'b1; end
              else begin d_drop = job_q[j]; drop_valid = 1'b1; end
              job_q.delete(j);
              break;
            end
      end
      free_ready = ($urandom % 4) != 0;
      tick();
      if (k == 1500) begin
        mid_cyc = cyc;
        for (int i = 0; i < N; i++) mid_bytes[i] = bytes[i];
      end
    end
    for (int i = 0; i < N; i++) begin
      chk(bytes[i] <= longint'(rate_v[i]) * (cyc - cyc_cfg[i]), "R3 long-run rate",
          bytes[i], longint'(rate_v[i]) * (cyc - cyc_cfg[i]));
      chk(bytes[i] - mid_bytes[i] <= longint'(burst_v[i]) + longint'(rate_v[i]) * (cyc - mid_cyc + 1),
          "R3 window burst bound", bytes[i] - mid_bytes[i],
          longint'(burst_v[i]) + longint'(rate_v[i]) * (cyc - mid_cyc + 1));
    end

    // Drain: every job leaves, every pointer freed once
    free_ready = 1'b1;
    for (int k = 0; k < 5000; k++) begin
      bit quiet;
      for (int i = 0; i <= N; i++) begin
        bit idle;
        idle = (i < N) ? !in_valid[i] : !drop_valid;
        if (idle)
          for (int j = 0; j < job_q.size(); j++)
            if (int'(job_q[j].tgt) == i) begin
              if (i < N) begin d_in[i] = job_q[j]; in_valid[i] = 1'b1; end
              else begin d_drop = job_q[j]; drop_valid = 1'b1; end
              job_q.delete(j);
              break;
            end
      end
      tick();
      quiet = job_q.size() == 0 && in_valid == '0 && !drop_valid && exp_free.size() == 0 && !free_valid;
      for (int i = 0; i < N; i++) if (slot_v[i]) quiet = 0;
      if (quiet) break;
    end
    chk(exp_free.size() == 0 && !free_valid, "R6 all frees delivered", exp_free.size(), 0);
    begin
      int nb;
      nb = 0;
      for (int p = 0; p < (1<<PW); p++) if (busy[p]) nb++;
      chk(nb == 0, "R6 no pointer leaked", nb, 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule